// File: doc/BRIEF.md
# Twisted-Ring Counter with Pairwise State Decoder

This block counts through a fixed cycle of states by shifting a row of registers one place on every clock edge and feeding the complement of the last bit back into the first. With `W` register bits the cycle has `2*W` states. At the default `W = 4` the cycle has eight states. Each state is turned into its own active-high strobe. Each strobe is formed from only two counter bits: an adjacent pair, or the two end bits. No full-width compare is used. Other logic uses the strobes as cheap timing slots, for example for phase enables or sequencer steps.

The clear input acts at once and does not wait for a clock. Its release passes through a two-stage synchroniser, so the counter leaves the all-zero state on a known edge. The block also watches for register patterns that are not part of the cycle and raises a flag when it sees one. When self-correction is enabled, such a pattern is replaced with the all-zero state on the next edge. A synchronous seed input can load any pattern. This is how a run is started from a chosen state, and how recovery from a bad pattern is exercised.

There is no data stream at this block's edge. Every pin is a plain control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `twr_counter`

## Requirements
- R1: While `clr_i` is high, `count_o` is 0 and `state_hot_o` is 8'h01. This takes effect immediately after `clr_i` rises, without waiting for a clock edge.
- R2: After `clr_i` falls between edges, `count_o` stays 0 across the next two rising edges. It becomes 4'b0001 on the third rising edge.
- R3: On each rising edge with no load and no correction, `count_o[k]` takes the old `count_o[k-1]` for k = 1..W-1, and `count_o[0]` takes the inverted old `count_o[W-1]`.
- R4: Starting from 0, the values of `count_o` (bit 0 first in each string) are 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001. After these eight values the count returns to 0000.
- R5: The strobes are formed as follows. Strobe 0 is ~c0&~c3. Strobe k (k = 1..3) is c(k-1)&~ck. Strobe 4 is c0&c3. Strobe 4+k (k = 1..3) is ~c(k-1)&ck. Here cN is `count_o[N]` and strobe N is `state_hot_o[N]`. For each of the eight legal values, exactly one strobe is high, and its index is the position of that value in the R4 sequence.
- R6: `illegal_o` is high exactly when more than one adjacent pair (`count_o[k]`, `count_o[k+1]`) holds differing values.
- R7: If `fix_en_i` is high and `illegal_o` is high at a rising edge with no load, `count_o` becomes 0 at that edge. If `fix_en_i` is low, an illegal value shifts by the R3 rule.
- R8: If `ld_en_i` is high at a rising edge, `count_o` takes `ld_val_i`. Loading overrides both shifting and correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| clr_i | input | 1 | Asynchronous clear, active high; release is synchronised |
| ld_en_i | input | 1 | Synchronous seed load enable |
| ld_val_i | input | W | Seed pattern |
| fix_en_i | input | 1 | Enable reloading zero when the pattern is illegal |
| count_o | output | W | Raw register contents, bit 0 first in the chain |
| state_hot_o | output | 2*W | One strobe per state |
| illegal_o | output | 1 | Current pattern is outside the legal cycle |

## Verification
Several properties are checked by assertions at every edge. These are the shift rule, zeroing on correction, loading of the seed, the one-hot property of the strobes in every legal state, the fact that a legal state never leads to an illegal one without a load, and the zero state while clear is held. Other behaviour can only be shown by bench scenarios. These are the exact three-edge delay after clear is released, the clear taking effect between clock edges, the order of the eight states against a computed sequence over three full cycles, and the flag, strobe and next-state values for all sixteen register patterns with correction both off and on.

// File: rtl/twr_pkg.sv
package twr_pkg;

  localparam int unsigned TWR_MAX_W = 32;

  // A pattern is on the cycle when at most one adjacent bit pair differs.
  function automatic logic twr_is_legal(input logic [TWR_MAX_W-1:0] v,
                                        input int unsigned w);
    int unsigned flips;
    flips = 0;
    for (int unsigned k = 0; k < TWR_MAX_W - 1; k++) begin
      if (k + 1 < w) flips += 32'(v[k] ^ v[k+1]);
    end
    return (flips <= 1);
  endfunction

endpackage

// File: rtl/twr_release_sync.sv
module twr_release_sync (
  input  logic clk_i,
  input  logic clr_i,
  output logic run_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign run_o = stage2_q;

  a_r2_run_after_stage1: assert property (@(posedge clk_i)
    $rose(run_o) |-> $past(stage1_q));
endmodule

// File: rtl/twr_shift_core.sv
module twr_shift_core #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         run_i,
  input  logic         ld_en_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         fix_en_i,
  input  logic         bad_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_next;
  logic         zap;

  assign zap = fix_en_i & bad_i;

  always_comb begin
    if (ld_en_i)  q_next = ld_val_i;
    else if (zap) q_next = '0;
    else          q_next = {q_q[W-2:0], ~q_q[W-1]};
  end

  always_ff @(posedge clk_i or negedge run_i) begin
    if (!run_i) q_q <= '0;
    else        q_q <= q_next;
  end

  assign q_o = q_q;

  a_r3_shift_rule: assert property (@(posedge clk_i) disable iff (!run_i)
    (!ld_en_i && !zap) |=>
      (q_q[W-1:1] == $past(q_q[W-2:0])) && (q_q[0] == !$past(q_q[W-1])));

  a_r7_zero_on_fix: assert property (@(posedge clk_i) disable iff (!run_i)
    (!ld_en_i && fix_en_i && bad_i) |=> (q_q == '0));

  a_r8_seed_load: assert property (@(posedge clk_i) disable iff (!run_i)
    ld_en_i |=> (q_q == $past(ld_val_i)));
endmodule

// File: rtl/twr_code_check.sv
module twr_code_check #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] q_i,
  output logic         bad_o
);
  import twr_pkg::*;

  assign bad_o = !twr_is_legal(TWR_MAX_W'(q_i), W);
endmodule

// File: rtl/twr_state_decode.sv
module twr_state_decode #(
  parameter int unsigned W = 4,
  localparam int unsigned NS = 2 * W
) (
  input  logic [W-1:0]  q_i,
  output logic [NS-1:0] hot_o
);
  // First half of the cycle: a run of ones growing from bit 0.
  for (genvar k = 0; k < W; k++) begin : g_fill
    if (k == 0) begin : g_end
      assign hot_o[0] = ~q_i[0] & ~q_i[W-1];
    end else begin : g_pair
      assign hot_o[k] = q_i[k-1] & ~q_i[k];
    end
  end

  // Second half: the run of ones draining from bit 0.
  for (genvar k = 0; k < W; k++) begin : g_drain
    if (k == 0) begin : g_end
      assign hot_o[W] = q_i[0] & q_i[W-1];
    end else begin : g_pair
      assign hot_o[W+k] = ~q_i[k-1] & q_i[k];
    end
  end
endmodule

// File: rtl/twr_counter.sv
module twr_counter #(
  parameter int unsigned W = 4,
  localparam int unsigned NS = 2 * W
) (
  input  logic          clk_i,
  input  logic          clr_i,
  input  logic          ld_en_i,
  input  logic [W-1:0]  ld_val_i,
  input  logic          fix_en_i,
  output logic [W-1:0]  count_o,
  output logic [NS-1:0] state_hot_o,
  output logic          illegal_o
);
  logic         run;
  logic         bad;
  logic [W-1:0] q;

  twr_release_sync u_sync (
    .clk_i (clk_i),
    .clr_i (clr_i),
    .run_o (run)
  );

  twr_shift_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .run_i    (run),
    .ld_en_i  (ld_en_i),
    .ld_val_i (ld_val_i),
    .fix_en_i (fix_en_i),
    .bad_i    (bad),
    .q_o      (q)
  );

  twr_code_check #(.W(W)) u_check (
    .q_i   (q),
    .bad_o (bad)
  );

  twr_state_decode #(.W(W)) u_dec (
    .q_i   (q),
    .hot_o (state_hot_o)
  );

  assign count_o   = q;
  assign illegal_o = bad;

  a_r1_clear_zero: assert property (@(posedge clk_i)
    clr_i |-> (q == '0) && (state_hot_o == NS'(1)));

  a_r5_one_strobe: assert property (@(posedge clk_i) disable iff (!run)
    !bad |-> ($countones(state_hot_o) == 1));

  a_r4_stays_legal: assert property (@(posedge clk_i) disable iff (!run)
    (!bad && !ld_en_i) |=> !bad);
endmodule

// File: tb/twr_counter_tb_top.sv
module twr_counter_tb_top;
  localparam int W = 4;
  localparam int NS = 2 * W;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          clr;
  logic          ld_en;
  logic [W-1:0]  ld_val;
  logic          fix_en;
  logic [W-1:0]  count;
  logic [NS-1:0] hot;
  logic          illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  twr_counter #(.W(W)) dut_i (
    .clk_i       (clk),
    .clr_i       (clr),
    .ld_en_i     (ld_en),
    .ld_val_i    (ld_val),
    .fix_en_i    (fix_en),
    .count_o     (count),
    .state_hot_o (hot),
    .illegal_o   (illegal)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] shf(input logic [W-1:0] v);
    return {v[W-2:0], ~v[W-1]};
  endfunction

  function automatic bit bad_of(input logic [W-1:0] v);
    return $countones(v[W-2:0] ^ v[W-1:1]) > 1;
  endfunction

  // Value at position idx of the cycle, computed from the fill/drain shape.
  function automatic logic [W-1:0] code_at(input int idx);
    int ones;
    if (idx < W) return W'((1 << idx) - 1);
    ones = W - (idx - W);
    return W'((((1 << ones) - 1) << (idx - W)));
  endfunction

  function automatic logic [NS-1:0] hot_of(input logic [W-1:0] v);
    logic [NS-1:0] h;
    h[0] = !v[0] && !v[W-1];
    h[W] = v[0] && v[W-1];
    for (int k = 1; k < W; k++) begin
      h[k]     = v[k-1] && !v[k];
      h[W + k] = !v[k-1] && v[k];
    end
    return h;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] model;
    int idx;
    clr = 1'b1; ld_en = 1'b0; ld_val = '0; fix_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(count == 0, "R1 count held", int'(count), 0);
    chk(hot == NS'(1), "R1 strobe 0", int'(hot), 1);
    chk(illegal == 1'b0, "R6 zero legal", int'(illegal), 0);

    // R2: release lands mid-cycle; three edges until the first step.
    clr = 1'b0;
    @(negedge clk);
    chk(count == 0, "R2 after edge 1", int'(count), 0);
    @(negedge clk);
    chk(count == 0, "R2 after edge 2", int'(count), 0);
    @(negedge clk);
    chk(count == W'(1), "R2 after edge 3", int'(count), 1);

    // R3/R4/R5: three full cycles against the computed sequence.
    model = W'(1);
    idx = 1;
    for (int s = 0; s < 3 * NS; s++) begin
      chk(count == code_at(idx), "R4 sequence", int'(count), int'(code_at(idx)));
      chk(count == model, "R3 shift model", int'(count), int'(model));
      chk(hot == NS'(1 << idx), "R5 one strobe", int'(hot), 1 << idx);
      chk(illegal == 1'b0, "R6 legal run", int'(illegal), 0);
      @(negedge clk);
      model = shf(model);
      idx = (idx + 1) % NS;
    end

    // R1: clear acts between edges.
    #2 clr = 1'b1;
    #1;
    chk(count == 0, "R1 async clear", int'(count), 0);
    chk(hot == NS'(1), "R1 async strobe", int'(hot), 1);
    @(negedge clk);
    clr = 1'b0;
    repeat (3) @(negedge clk);

    // R5..R8: every pattern, correction off and on.
    for (int v = 0; v < (1 << W); v++) begin
      for (int fx = 0; fx < 2; fx++) begin
        logic [W-1:0] pv;
        logic [W-1:0] nx;
        pv = W'(v);
        fix_en = fx[0];
        ld_en = 1'b1;
        ld_val = pv;
        @(negedge clk);
        ld_en = 1'b0;
        chk(count == pv, "R8 seed load", int'(count), v);
        chk(illegal == bad_of(pv), "R6 flag", int'(illegal), int'(bad_of(pv)));
        chk(hot == hot_of(pv), "R5 strobe terms", int'(hot), int'(hot_of(pv)));
        nx = (fx == 1 && bad_of(pv)) ? '0 : shf(pv);
        @(negedge clk);
        if (bad_of(pv))
          chk(count == nx, "R7 illegal next", int'(count), int'(nx));
        else
          chk(count == nx, "R3 next after load", int'(count), int'(nx));
      end
    end
    fix_en = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule